// File: doc/BRIEF.md
# Debug Single-Step and Resume Sequencer

This block is the command engine of a microcontroller's on-chip debug unit. Once the CPU has been parked in debug mode, the host can send one of two commands. A step command lets exactly one user instruction run and then forces the CPU back into debug. A resume command hands control back to the user program. Each command runs as a fixed, ordered series of steps. The steps drive a stack pop/push port and an instruction-supply port, both of which use ready handshakes. They also drive CPU stall, fetch-block and halt lines, write the instruction pointer, and write the interrupt-enable and memory-mode flags.

When debug mode is entered, the block latches the interrupt-enable and memory-mode flags. It restores the interrupt-enable flag while an instruction runs, and it restores the memory-mode flag on resume. It reports a 2-bit status. Internal timers are held off while the CPU is in debug, and a clock switchback is requested on entry when that is enabled. A breakpoint match on the first instruction after a resume does not cause a break.

Top module: `dbg_step_seq`

## Requirements
- R1: `status` reads 2'b00 outside debug, 2'b10 while a command runs, and 2'b01 when the sequencer is idle in debug mode; 2'b11 never appears.
- R2: A step runs in this order: pop the return address, supply the instruction at that address, then push (with `cpu_stall` and `fetch_block` high), then a final cycle that writes `TRAP_VEC` (default 16'h8010) to the instruction pointer with `cpu_halt` high, then idle.
- R3: The interrupt-enable flag is written to 1 on the pop of a step or a resume only if it was 1 when debug mode was entered. It is written to 0 in the final cycle of a step.
- R4: The memory-mode flag is captured on debug entry and written to 0 in the final cycle of a step. On the pop of a resume, the captured value is written back.
- R5: The address pushed by a step is the popped return address plus one.
- R6: A resume pops the return address, supplies the instruction at that address, then leaves debug mode with `status` 2'b00 and `cpu_halt` low.
- R7: Each pop, push and instruction supply holds its request and its address until the matching ready input is high.
- R8: If `multi_region` is high and the popped address is at or above `SYS_BASE` (default 16'h8000), the step is refused. `cmd_err` pulses, the same address is pushed back, no interrupt-enable write is made, and the sequencer returns to idle.
- R9: A step or resume command that arrives while the sequencer is busy or outside debug mode has no effect on the sequence and pulses `cmd_err` in the same cycle.
- R10: After a resume, `bp_break` stays low for a breakpoint match on the first completed instruction. A match on any later instruction raises it.
- R11: `timer_en` is high exactly when the sequencer is outside debug mode.
- R12: `clk_switchback` pulses when debug mode is entered and `swb_en` is high. It stays low when `swb_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dbg_enter | input | 1 | Pulse: CPU enters debug mode |
| trace_cmd | input | 1 | Pulse: host step command |
| return_cmd | input | 1 | Pulse: host resume command |
| ige_in | input | 1 | Interrupt-enable flag value at entry |
| upa_in | input | 1 | Memory-mode flag value at entry |
| swb_en | input | 1 | Clock switchback enable |
| multi_region | input | 1 | Multiple memory regions defined |
| stack_rdy | input | 1 | Stack operation completes this cycle |
| pop_data | input | AW | Popped return address |
| stk_pop | output | 1 | Stack pop request |
| stk_push | output | 1 | Stack push request |
| push_data | output | AW | Address to push |
| ins_rdy | input | 1 | Supplied instruction has executed |
| ins_req | output | 1 | Instruction supply request |
| ins_addr | output | AW | Address of supplied instruction |
| cpu_stall | output | 1 | Stall CPU after the stepped instruction |
| fetch_block | output | 1 | Block the next program fetch |
| cpu_halt | output | 1 | Halt CPU |
| ip_wr | output | 1 | Instruction pointer write strobe |
| ip_wdata | output | AW | Instruction pointer write value |
| ige_wr | output | 1 | Interrupt-enable write strobe |
| ige_wdata | output | 1 | Interrupt-enable write value |
| upa_wr | output | 1 | Memory-mode write strobe |
| upa_wdata | output | 1 | Memory-mode write value |
| status | output | 2 | Debug status |
| timer_en | output | 1 | Internal timer enable |
| clk_switchback | output | 1 | Request divide-by-1 system clock |
| insn_done | input | 1 | A user instruction completed |
| bp_match | input | 1 | Breakpoint comparator hit for that instruction |
| bp_break | output | 1 | Breakpoint break request |
| cmd_err | output | 1 | Refused or ignored command |

## Verification
The assertions check the properties that can be judged on every cycle. The status code 2'b11 must never appear. Pop and instruction-supply requests must hold until their ready input arrives, and the supply address must stay stable meanwhile. Timers must run only outside debug. An instruction-pointer write must come only with halt and fetch-block high. A switchback request must come only with its enable set. A stray command outside debug must leave the status unchanged. The bench scenarios are needed for the behaviours that depend on history: the order of the steps, the flag values latched at entry and written back later, the incremented push address, refusal of a step in system memory, and masking of exactly the first breakpoint after a resume.

// File: rtl/dbg_seq_pkg.sv
package dbg_seq_pkg;
  typedef enum logic [3:0] {
    ST_BG    = 4'd0,
    ST_IDLE  = 4'd1,
    ST_TPOP  = 4'd2,
    ST_TEXEC = 4'd3,
    ST_TPUSH = 4'd4,
    ST_TFIN  = 4'd5,
    ST_TREJ  = 4'd6,
    ST_RPOP  = 4'd7,
    ST_REXEC = 4'd8
  } seq_st_e;

  localparam logic [1:0] STAT_NONDBG = 2'b00;
  localparam logic [1:0] STAT_IDLE   = 2'b01;
  localparam logic [1:0] STAT_BUSY   = 2'b10;
endpackage

// File: rtl/dbg_seq_fsm.sv
module dbg_seq_fsm
  import dbg_seq_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    dbg_enter,
  input  logic    trace_cmd,
  input  logic    return_cmd,
  input  logic    stack_rdy,
  input  logic    ins_rdy,
  input  logic    reject,
  output seq_st_e state
);
  seq_st_e state_d;

  always_comb begin
    state_d = state;
    case (state)
      ST_BG:    if (dbg_enter) state_d = ST_IDLE;
      ST_IDLE:  if (trace_cmd) state_d = ST_TPOP;
                else if (return_cmd) state_d = ST_RPOP;
      ST_TPOP:  if (stack_rdy) state_d = reject ? ST_TREJ : ST_TEXEC;
      ST_TEXEC: if (ins_rdy) state_d = ST_TPUSH;
      ST_TPUSH: if (stack_rdy) state_d = ST_TFIN;
      ST_TFIN:  state_d = ST_IDLE;
      ST_TREJ:  if (stack_rdy) state_d = ST_IDLE;
      ST_RPOP:  if (stack_rdy) state_d = ST_REXEC;
      ST_REXEC: if (ins_rdy) state_d = ST_BG;
      default:  state_d = ST_BG;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_BG;
    else        state <= state_d;
  end
endmodule

// File: rtl/dbg_ctx_store.sv
module dbg_ctx_store #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          entry_en,
  input  logic          ige_in,
  input  logic          upa_in,
  input  logic          addr_en,
  input  logic [AW-1:0] addr_in,
  output logic          ige_sv,
  output logic          upa_sv,
  output logic [AW-1:0] ret_addr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ige_sv <= 1'b0;
      upa_sv <= 1'b0;
    end else if (entry_en) begin
      ige_sv <= ige_in;
      upa_sv <= upa_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ret_addr <= '0;
    else if (addr_en) ret_addr <= addr_in;
  end
endmodule

// File: rtl/dbg_bp_gate.sv
module dbg_bp_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic in_bg,
  input  logic insn_done,
  input  logic bp_match,
  output logic bp_break
);
  logic mask_q, mask_d;

  always_comb begin
    mask_d = mask_q;
    if (arm)                     mask_d = 1'b1;
    else if (in_bg && insn_done) mask_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= 1'b0;
    else        mask_q <= mask_d;
  end

  assign bp_break = in_bg && insn_done && bp_match && !mask_q;
endmodule

// File: rtl/dbg_step_seq.sv
module dbg_step_seq
  import dbg_seq_pkg::*;
#(
  parameter int              AW       = 16,
  parameter logic [AW-1:0]   TRAP_VEC = 16'h8010,
  parameter logic [AW-1:0]   SYS_BASE = 16'h8000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dbg_enter,
  input  logic          trace_cmd,
  input  logic          return_cmd,
  input  logic          ige_in,
  input  logic          upa_in,
  input  logic          swb_en,
  input  logic          multi_region,
  input  logic          stack_rdy,
  input  logic [AW-1:0] pop_data,
  output logic          stk_pop,
  output logic          stk_push,
  output logic [AW-1:0] push_data,
  input  logic          ins_rdy,
  output logic          ins_req,
  output logic [AW-1:0] ins_addr,
  output logic          cpu_stall,
  output logic          fetch_block,
  output logic          cpu_halt,
  output logic          ip_wr,
  output logic [AW-1:0] ip_wdata,
  output logic          ige_wr,
  output logic          ige_wdata,
  output logic          upa_wr,
  output logic          upa_wdata,
  output logic [1:0]    status,
  output logic          timer_en,
  output logic          clk_switchback,
  input  logic          insn_done,
  input  logic          bp_match,
  output logic          bp_break,
  output logic          cmd_err
);
  seq_st_e       state;
  logic          reject, pop_hs, in_bg, entry_en;
  logic          ige_sv, upa_sv;
  logic [AW-1:0] ret_addr;

  assign in_bg    = (state == ST_BG);
  assign entry_en = in_bg && dbg_enter;
  assign stk_pop  = (state == ST_TPOP) || (state == ST_RPOP);
  assign pop_hs   = stk_pop && stack_rdy;
  assign reject   = multi_region && (pop_data >= SYS_BASE);

  dbg_seq_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .dbg_enter(dbg_enter), .trace_cmd(trace_cmd),
    .return_cmd(return_cmd), .stack_rdy(stack_rdy), .ins_rdy(ins_rdy),
    .reject(reject), .state(state)
  );

  dbg_ctx_store #(.AW(AW)) u_ctx (
    .clk(clk), .rst_n(rst_n), .entry_en(entry_en), .ige_in(ige_in),
    .upa_in(upa_in), .addr_en(pop_hs), .addr_in(pop_data),
    .ige_sv(ige_sv), .upa_sv(upa_sv), .ret_addr(ret_addr)
  );

  dbg_bp_gate u_bp (
    .clk(clk), .rst_n(rst_n), .arm((state == ST_REXEC) && ins_rdy),
    .in_bg(in_bg), .insn_done(insn_done), .bp_match(bp_match),
    .bp_break(bp_break)
  );

  always_comb begin
    case (state)
      ST_BG:   status = STAT_NONDBG;
      ST_IDLE: status = STAT_IDLE;
      default: status = STAT_BUSY;
    endcase
  end

  assign timer_en       = in_bg;
  assign clk_switchback = entry_en && swb_en;

  assign stk_push  = (state == ST_TPUSH) || (state == ST_TREJ);
  assign push_data = (state == ST_TPUSH) ? ret_addr + 1'b1 : ret_addr;

  assign ins_req  = (state == ST_TEXEC) || (state == ST_REXEC);
  assign ins_addr = ret_addr;

  assign cpu_stall   = (state == ST_TPUSH) || (state == ST_TFIN);
  assign fetch_block = cpu_stall;
  assign cpu_halt    = !(in_bg || ins_req);

  assign ip_wr    = (state == ST_TFIN);
  assign ip_wdata = TRAP_VEC;

  assign ige_wr    = ip_wr || (pop_hs && ige_sv && !((state == ST_TPOP) && reject));
  assign ige_wdata = !ip_wr;

  assign upa_wr    = ip_wr || ((state == ST_RPOP) && stack_rdy);
  assign upa_wdata = (state == ST_RPOP) ? upa_sv : 1'b0;

  assign cmd_err = ((trace_cmd || return_cmd) && (state != ST_IDLE)) ||
                   ((state == ST_TPOP) && stack_rdy && reject);
endmodule

// File: rtl/dbg_step_seq_chk.sv
module dbg_step_seq_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    status,
  input logic          timer_en,
  input logic          stk_pop,
  input logic          stack_rdy,
  input logic          ins_req,
  input logic          ins_rdy,
  input logic [AW-1:0] ins_addr,
  input logic          ip_wr,
  input logic          cpu_halt,
  input logic          fetch_block,
  input logic          clk_switchback,
  input logic          swb_en,
  input logic          trace_cmd,
  input logic          return_cmd,
  input logic          dbg_enter
);
  // R1
  status_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status != 2'b11);

  // R7
  pop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stk_pop && !stack_rdy |=> stk_pop);

  // R7
  supply_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ins_req && !ins_rdy |=> ins_req && $stable(ins_addr));

  // R11
  timer_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timer_en == (status == 2'b00));

  // R2
  vector_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ip_wr |-> cpu_halt && fetch_block && status == 2'b10);

  // R12
  switchback_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clk_switchback |-> swb_en);

  // R9
  stray_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trace_cmd || return_cmd) && status == 2'b00 && !dbg_enter |=> status == 2'b00);
endmodule

bind dbg_step_seq dbg_step_seq_chk #(.AW(AW)) u_chk (.*);

// File: tb/tb_dbg_step_seq.sv
`timescale 1ns/1ps
module tb_dbg_step_seq;
  localparam int AW = 16;
  localparam logic [AW-1:0] VEC_TRAP = 16'h8010;
  localparam logic [AW-1:0] SYS_LO   = 16'h8000;

  // {addr, ige at entry, upa at entry, multi_region}
  localparam int NV = 5;
  localparam logic [18:0] VEC [NV] = '{
    {16'h0100, 1'b1, 1'b1, 1'b0},
    {16'h9000, 1'b0, 1'b0, 1'b0},
    {16'h9000, 1'b1, 1'b0, 1'b1},
    {16'h7FFF, 1'b0, 1'b1, 1'b1},
    {16'h8000, 1'b1, 1'b1, 1'b1}
  };

  logic clk = 1'b0, rst_n;
  logic dbg_enter, trace_cmd, return_cmd, ige_in, upa_in, swb_en, multi_region;
  logic stack_rdy, ins_rdy, insn_done, bp_match;
  logic [AW-1:0] pop_data;
  logic stk_pop, stk_push, ins_req, cpu_stall, fetch_block, cpu_halt, ip_wr;
  logic ige_wr, ige_wdata, upa_wr, upa_wdata, timer_en, clk_switchback, bp_break, cmd_err;
  logic [AW-1:0] push_data, ins_addr, ip_wdata;
  logic [1:0] status;
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  dbg_step_seq dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wrap_up();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  task automatic enter(input logic ig, input logic up);
    @(negedge clk);
    ige_in = ig; upa_in = up; dbg_enter = 1'b1;
    #1 chk("R12 switchback", clk_switchback, swb_en);
    @(negedge clk);
    dbg_enter = 1'b0;
    chk("R1 idle status", status, 2'b01);
    chk("R11 timers off", timer_en, 1'b0);
  endtask

  task automatic do_trace(input logic [AW-1:0] a, input logic ig, input logic mr);
    logic rej;
    rej = mr && (a >= SYS_LO);
    multi_region = mr;
    trace_cmd = 1'b1;
    @(negedge clk);
    trace_cmd = 1'b0;
    chk("R1 busy status", status, 2'b10);
    chk("R2 pop first", stk_pop, 1'b1);
    return_cmd = 1'b1;
    #1 chk("R9 busy cmd_err", cmd_err, 1'b1);
    @(negedge clk);
    return_cmd = 1'b0;
    chk("R7 pop held", stk_pop, 1'b1);
    chk("R9 busy ignored", status, 2'b10);
    stack_rdy = 1'b1; pop_data = a;
    #1;
    chk("R3 ige on step pop", ige_wr, ig && !rej);
    chk("R8 reject flag", cmd_err, rej);
    @(negedge clk);
    stack_rdy = 1'b0;
    if (rej) begin
      chk("R8 push back", {stk_push, push_data}, {1'b1, a});
      stack_rdy = 1'b1;
      @(negedge clk);
      stack_rdy = 1'b0;
      chk("R8 back to idle", status, 2'b01);
      return;
    end
    chk("R2 supply", {ins_req, ins_addr}, {1'b1, a});
    chk("R2 cpu runs", {cpu_halt, cpu_stall}, 2'b00);
    @(negedge clk);
    chk("R7 supply held", {ins_req, ins_addr}, {1'b1, a});
    ins_rdy = 1'b1;
    @(negedge clk);
    ins_rdy = 1'b0;
    chk("R2 stall+block", {cpu_stall, fetch_block, stk_push}, 3'b111);
    chk("R5 push incr", push_data, a + 16'd1);
    stack_rdy = 1'b1;
    @(negedge clk);
    stack_rdy = 1'b0;
    chk("R2 vector", {ip_wr, ip_wdata, cpu_halt}, {1'b1, VEC_TRAP, 1'b1});
    chk("R3 ige clear", {ige_wr, ige_wdata}, 2'b10);
    chk("R4 upa clear", {upa_wr, upa_wdata}, 2'b10);
    @(negedge clk);
    chk("R1 idle after step", status, 2'b01);
  endtask

  task automatic do_return(input logic [AW-1:0] a, input logic ig, input logic up);
    return_cmd = 1'b1;
    @(negedge clk);
    return_cmd = 1'b0;
    chk("R6 pop", {status, stk_pop}, {2'b10, 1'b1});
    stack_rdy = 1'b1; pop_data = a;
    #1;
    chk("R4 upa restore", {upa_wr, upa_wdata}, {1'b1, up});
    chk("R3 ige on resume", ige_wr, ig);
    @(negedge clk);
    stack_rdy = 1'b0;
    chk("R6 supply", {ins_req, ins_addr}, {1'b1, a});
    ins_rdy = 1'b1;
    @(negedge clk);
    ins_rdy = 1'b0;
    chk("R6 released", {status, cpu_halt}, 3'b000);
    chk("R11 timers on", timer_en, 1'b1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog act=hung exp=done");
    wrap_up();
  end

  initial begin
    rst_n = 1'b0;
    {dbg_enter, trace_cmd, return_cmd, ige_in, upa_in, multi_region} = '0;
    {stack_rdy, ins_rdy, insn_done, bp_match} = '0;
    swb_en = 1'b1; pop_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset status", status, 2'b00);
    chk("R11 reset timers", timer_en, 1'b1);
    chk("R6 reset no halt", {cpu_halt, stk_pop, ins_req}, 3'b000);

    for (int i = 0; i < NV; i++) begin
      swb_en = i[0];
      enter(VEC[i][2], VEC[i][1]);
      do_trace(VEC[i][18:3], VEC[i][2], VEC[i][0]);
      do_return(VEC[i][18:3] + 16'd1, VEC[i][2], VEC[i][1]);
    end

    // R9: command outside debug
    @(negedge clk);
    trace_cmd = 1'b1;
    #1 chk("R9 nondebug cmd_err", cmd_err, 1'b1);
    @(negedge clk);
    trace_cmd = 1'b0;
    chk("R9 nondebug ignored", {status, stk_pop}, 3'b000);

    // R10: first breakpoint after resume masked, next breaks
    swb_en = 1'b0;
    enter(1'b0, 1'b0);
    do_return(16'h0200, 1'b0, 1'b0);
    insn_done = 1'b1; bp_match = 1'b1;
    #1 chk("R10 first masked", bp_break, 1'b0);
    @(negedge clk);
    #1 chk("R10 second breaks", bp_break, 1'b1);
    @(negedge clk);
    insn_done = 1'b0; bp_match = 1'b0;
    wrap_up();
  end
endmodule